// File: doc/BRIEF.md
# Serial Token and Configuration Chain Node

This block is the per-chip end of one serial wire that threads through every memory chip of a frame buffer. The same wire does two jobs, and a two-bit mode input chooses between them. During initialization it is a scan chain. A first pass loads one Alive bit per chip. A second pass loads a configuration word into every chip whose Alive bit is set. Chips marked faulty are skipped without delay, so that pass sees only the good chips.

During normal operation the wire carries a single global token that stands in for address decoding on the video read side. A chip that receives the token raises its chip select. Its local one-hot pointer then visits every pixel in scan-line order, one pixel per clock. After the last pixel the chip drops its select and passes the token down the wire to the next chip. A faulty chip never selects itself and lets the token straight through.

The configuration word holds a supertree path field, a spare-column address, and separate enables for the spare row and spare column. These fields are presented as static outputs for neighbouring logic.

Top module: `scan_token_node`

## Requirements
- R1: While rst_n is low at a clock edge, all state clears: alive, chip_sel, pix_sel and every configuration field read 0. With mode 11 applied, scan_out also reads 0.
- R2: Mode 01 loads the Alive bit: each clock copies scan_in into alive, and scan_out equals alive, so scan_out repeats scan_in one clock later.
- R3: Mode 10 with alive = 1 shifts the configuration word one place per clock. scan_in enters at bit 0, and scan_out shows bit CFG_W-1 before the edge. After CFG_W clocks, the word's bit 0 is red_row_en, bit 1 is red_col_en, bits COL_AW+1..2 are red_col_addr, and the top TREE_LVLS bits are tree_path.
- R4: Mode 10 with alive = 0 ties scan_out to scan_in within the same cycle and leaves every configuration field unchanged.
- R5: The configuration fields change only in mode 10. The alive output changes only in mode 01.
- R6: Mode 00 with alive = 1 and no token held: scan_in = 1 at an edge makes chip_sel = 1 and pix_sel = 1 (pixel 0) after that edge.
- R7: While the token is held, pix_sel moves up one pixel per clock and never has more than one bit set. chip_sel equals the OR of pix_sel.
- R8: On the clock after pixel NPIX-1, chip_sel and pix_sel return to 0 and scan_out is 1 for exactly one cycle. In mode 00 with alive = 1, scan_out is otherwise 0.
- R9: Mode 00 with alive = 0 never raises chip_sel and ties scan_out to scan_in within the same cycle.
- R10: scan_in = 1 while a token is already held does not restart or disturb the pixel walk.
- R11: Mode 11 holds all state and drives scan_out to 0. Leaving mode 00 drops a held token, and returning to mode 00 does not revive it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode | input | 2 | 00 run, 01 Alive load, 10 configuration load, 11 hold |
| scan_in | input | 1 | Serial path from previous chip |
| scan_out | output | 1 | Serial path to next chip |
| chip_sel | output | 1 | This chip drives video data |
| pix_sel | output | NPIX | One-hot selected pixel |
| alive | output | 1 | Module marked good |
| red_row_en | output | 1 | Spare row enable |
| red_col_en | output | 1 | Spare column enable |
| red_col_addr | output | COL_AW | Column replaced by the spare |
| tree_path | output | TREE_LVLS | Supertree path bits |

## Verification
A corrupted configuration register appears at scan_out within CFG_W clocks, because the next load shifts the old contents out bit by bit. It also appears at the field outputs as soon as the load completes. A fault in the pointer shows up at pix_sel on the very next clock as a skipped, doubled or restarted pixel. A fault in the token hand-off shows up NPIX+1 clocks after capture, as a missing or stretched pulse on scan_out. A wrong Alive bit changes scan_out timing in the same cycle: the path either bypasses the chip or adds a stage.

// File: rtl/scan_pkg.sv
// Shared mode encoding for the serial token and configuration chain.
package scan_pkg;
    typedef enum logic [1:0] {
        MODE_RUN   = 2'b00,
        MODE_ALIVE = 2'b01,
        MODE_CFG   = 2'b10,
        MODE_HOLD  = 2'b11
    } scan_mode_e;
endpackage

// File: rtl/alive_cell.sv
// One-bit module-health flag loaded from the serial path.
// Assumes load_en is asserted only during the Alive pass.
module alive_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic load_en,
    input  logic d,
    output logic q
);
    // Capture the serial bit while loading, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else if (load_en)
            q <= d;
    end
endmodule

// File: rtl/cfg_shreg.sv
// Configuration shift register: serial in at bit 0, serial out at the top bit.
// Assumes W >= 2.
module cfg_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         d,
    output logic [W-1:0] q
);
    // Shift one place toward the top bit when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (shift_en)
            q <= {q[W-2:0], d};
    end
endmodule

// File: rtl/token_walker.sv
// Local token: captures the global token, walks a one-hot pointer across
// NPIX pixels one per clock, then emits a one-cycle token pulse.
// Assumes NPIX >= 2; run_en low clears all state.
module token_walker #(
    parameter int NPIX = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_en,
    input  logic            tok_in,
    output logic [NPIX-1:0] ptr,
    output logic            tok_out
);
    logic holding;
    assign holding = |ptr;

    // Pointer: load pixel 0 on capture, shift up while held, clear past the end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en)
            ptr <= '0;
        else if (holding)
            ptr <= {ptr[NPIX-2:0], 1'b0};
        else if (tok_in)
            ptr <= {{(NPIX-1){1'b0}}, 1'b1};
    end

    // Forward the token on the clock after the last pixel.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en)
            tok_out <= 1'b0;
        else
            tok_out <= ptr[NPIX-1];
    end
endmodule

// File: rtl/scan_token_node.sv
// Per-chip node on the shared serial path.
// Mode 01 loads the Alive bit (always in chain). Mode 10 loads the
// configuration word through good chips and bypasses faulty ones.
// Mode 00 passes the video token; mode 11 holds.
// Assumes a single token circulates in run mode.
module scan_token_node #(
    parameter int NPIX      = 64,
    parameter int COL_AW    = 6,
    parameter int TREE_LVLS = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           mode,
    input  logic                 scan_in,
    output logic                 scan_out,
    output logic                 chip_sel,
    output logic [NPIX-1:0]      pix_sel,
    output logic                 alive,
    output logic                 red_row_en,
    output logic                 red_col_en,
    output logic [COL_AW-1:0]    red_col_addr,
    output logic [TREE_LVLS-1:0] tree_path
);
    import scan_pkg::*;

    localparam int COL_LO = 2;
    localparam int COL_HI = COL_LO + COL_AW - 1;
    localparam int TRE_LO = COL_HI + 1;
    localparam int CFG_W  = TRE_LO + TREE_LVLS;

    scan_mode_e      md;
    logic [CFG_W-1:0] cfg_q;
    logic            tok_q;
    logic            run_en;

    assign md     = scan_mode_e'(mode);
    assign run_en = alive && (md == MODE_RUN);

    alive_cell u_alive (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (md == MODE_ALIVE),
        .d       (scan_in),
        .q       (alive)
    );

    cfg_shreg #(.W(CFG_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (alive && (md == MODE_CFG)),
        .d        (scan_in),
        .q        (cfg_q)
    );

    token_walker #(.NPIX(NPIX)) u_walk (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .tok_in  (scan_in),
        .ptr     (pix_sel),
        .tok_out (tok_q)
    );

    assign chip_sel     = |pix_sel;
    assign red_row_en   = cfg_q[0];
    assign red_col_en   = cfg_q[1];
    assign red_col_addr = cfg_q[COL_HI:COL_LO];
    assign tree_path    = cfg_q[CFG_W-1:TRE_LO];

    // Route the serial path according to mode and module health.
    always_comb begin
        unique case (md)
            MODE_RUN:   scan_out = alive ? tok_q : scan_in;
            MODE_ALIVE: scan_out = alive;
            MODE_CFG:   scan_out = alive ? cfg_q[CFG_W-1] : scan_in;
            default:    scan_out = 1'b0;
        endcase
    end
endmodule

// File: rtl/scan_token_node_chk.sv
// Property checker for scan_token_node, attached by bind.
module scan_token_node_chk #(
    parameter int NPIX      = 64,
    parameter int COL_AW    = 6,
    parameter int TREE_LVLS = 14
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [1:0]           mode,
    input logic                 scan_in,
    input logic                 scan_out,
    input logic                 chip_sel,
    input logic [NPIX-1:0]      pix_sel,
    input logic                 alive,
    input logic                 red_row_en,
    input logic                 red_col_en,
    input logic [COL_AW-1:0]    red_col_addr,
    input logic [TREE_LVLS-1:0] tree_path
);
    logic [COL_AW+TREE_LVLS+1:0] fields;
    assign fields = {tree_path, red_col_addr, red_col_en, red_row_en};

    // R2
    alive_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && mode == 2'b01 && $past(mode) == 2'b01) |-> scan_out == $past(scan_in));

    // R4
    dead_cfg_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && !alive) |-> scan_out == scan_in);

    // R5
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode) != 2'b10) |-> $stable(fields));

    // R5
    alive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode) != 2'b01) |-> $stable(alive));

    // R7
    one_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pix_sel) && (chip_sel == (|pix_sel)));

    // R8
    handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(chip_sel) && mode == 2'b00 && $past(mode) == 2'b00) |-> scan_out);

    // R9
    dead_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !alive |-> !chip_sel);

    // R11
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11) |-> !scan_out);
endmodule

bind scan_token_node scan_token_node_chk #(
    .NPIX(NPIX), .COL_AW(COL_AW), .TREE_LVLS(TREE_LVLS)
) chk_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .scan_in(scan_in),
    .scan_out(scan_out), .chip_sel(chip_sel), .pix_sel(pix_sel),
    .alive(alive), .red_row_en(red_row_en), .red_col_en(red_col_en),
    .red_col_addr(red_col_addr), .tree_path(tree_path)
);

// File: tb/scan_token_node_tb_top.sv
`timescale 1ns/1ps
module scan_token_node_tb_top;
    localparam int NPIX  = 4;
    localparam int CAW   = 3;
    localparam int TL    = 4;
    localparam int CFG_W = TL + CAW + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mode = 2'b11;
    logic scan_in = 1'b0;
    logic scan_out, chip_sel, alive, red_row_en, red_col_en;
    logic [NPIX-1:0] pix_sel;
    logic [CAW-1:0] red_col_addr;
    logic [TL-1:0] tree_path;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    scan_token_node #(.NPIX(NPIX), .COL_AW(CAW), .TREE_LVLS(TL)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .scan_in(scan_in),
        .scan_out(scan_out), .chip_sel(chip_sel), .pix_sel(pix_sel),
        .alive(alive), .red_row_en(red_row_en), .red_col_en(red_col_en),
        .red_col_addr(red_col_addr), .tree_path(tree_path)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int fields_now();
        return int'({tree_path, red_col_addr, red_col_en, red_row_en});
    endfunction

    // Advance to the next falling edge, then let combinational paths settle.
    task automatic nxt();
        @(negedge clk);
        #0.5;
    endtask

    task automatic set_alive(input bit v);
        mode = 2'b01; scan_in = v;
        nxt();
        mode = 2'b11; scan_in = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [CFG_W-1:0] old_v;
        bit prev;
        bit [7:0] pat;
        old_v = '0;
        repeat (3) nxt();
        rst_n = 1'b1;
        // R1: reset state
        chk(scan_out == 1'b0 && chip_sel == 1'b0, "R1 sel/out", int'({scan_out, chip_sel}), 0);
        chk(pix_sel == '0 && alive == 1'b0, "R1 pix/alive", int'({pix_sel, alive}), 0);
        chk(fields_now() == 0, "R1 fields", fields_now(), 0);

        // R2: Alive pass echoes scan_in one clock late
        pat = 8'b1011_0101;
        prev = 1'b0;
        mode = 2'b01;
        for (int i = 0; i < 8; i++) begin
            scan_in = pat[i];
            #0.5;
            chk(scan_out == prev, "R2 echo", int'(scan_out), int'(prev));
            prev = pat[i];
            nxt();
        end
        mode = 2'b11; scan_in = 1'b0;
        #0.5;
        chk(alive == 1'b1, "R2 alive loaded", int'(alive), 1);

        // R3: sweep every configuration word; old contents stream out
        mode = 2'b10;
        for (int v = 0; v < (1 << CFG_W); v++) begin
            for (int k = 0; k < CFG_W; k++) begin
                scan_in = v[CFG_W-1-k];
                #0.5;
                chk(scan_out == old_v[CFG_W-1-k], "R3 shift out", int'(scan_out), int'(old_v[CFG_W-1-k]));
                nxt();
            end
            chk(int'(red_row_en) == v[0], "R3 row_en", int'(red_row_en), v[0]);
            chk(int'(red_col_en) == v[1], "R3 col_en", int'(red_col_en), v[1]);
            chk(int'(red_col_addr) == ((v >> 2) & ((1 << CAW) - 1)), "R3 col_addr",
                int'(red_col_addr), (v >> 2) & ((1 << CAW) - 1));
            chk(int'(tree_path) == (v >> (CAW + 2)), "R3 tree_path", int'(tree_path), v >> (CAW + 2));
            old_v = CFG_W'(v);
        end
        old_v = CFG_W'(9'h15A);
        for (int k = 0; k < CFG_W; k++) begin
            scan_in = old_v[CFG_W-1-k];
            nxt();
        end

        // R11: hold mode quiet, state kept
        mode = 2'b11;
        scan_in = 1'b1;
        for (int i = 0; i < 3; i++) begin
            #0.5;
            chk(scan_out == 1'b0, "R11 hold out", int'(scan_out), 0);
            nxt();
        end
        chk(fields_now() == int'(old_v), "R5 fields held in hold", fields_now(), int'(old_v));
        chk(alive == 1'b1, "R5 alive held", int'(alive), 1);

        // R6 R7 R8 R10: token walks, with a spurious token at each pixel
        mode = 2'b00;
        scan_in = 1'b0;
        nxt();
        for (int j = 0; j <= NPIX; j++) begin
            scan_in = 1'b1;
            #0.5;
            chk(scan_out == 1'b0, "R8 no echo when alive", int'(scan_out), 0);
            nxt();
            for (int p = 0; p < NPIX; p++) begin
                chk(int'(pix_sel) == (1 << p), (p == 0) ? "R6 capture" : "R7/R10 advance",
                    int'(pix_sel), 1 << p);
                chk(chip_sel == 1'b1 && scan_out == 1'b0, "R7 sel held", int'({chip_sel, scan_out}), 2);
                scan_in = (p == j);
                nxt();
            end
            scan_in = 1'b0;
            chk(chip_sel == 1'b0 && pix_sel == '0, "R8 release", int'({chip_sel, pix_sel}), 0);
            chk(scan_out == 1'b1, "R8 forward", int'(scan_out), 1);
            nxt();
            chk(scan_out == 1'b0 && chip_sel == 1'b0, "R8 single pulse", int'({scan_out, chip_sel}), 0);
            nxt();
        end
        chk(fields_now() == int'(old_v), "R5 fields held in run", fields_now(), int'(old_v));

        // R11: leaving run drops a held token
        scan_in = 1'b1;
        nxt();
        scan_in = 1'b0;
        mode = 2'b11;
        nxt();
        chk(chip_sel == 1'b0 && pix_sel == '0, "R11 drop on exit", int'({chip_sel, pix_sel}), 0);
        mode = 2'b00;
        nxt();
        chk(chip_sel == 1'b0, "R11 no revival", int'(chip_sel), 0);
        mode = 2'b11;
        nxt();

        // R4: faulty module bypassed in config pass, fields untouched
        set_alive(1'b0);
        mode = 2'b10;
        for (int i = 0; i < 6; i++) begin
            scan_in = i[0];
            #0.5;
            chk(scan_out == scan_in, "R4 bypass", int'(scan_out), int'(scan_in));
            nxt();
        end
        chk(fields_now() == int'(old_v), "R4 fields unchanged", fields_now(), int'(old_v));

        // R9: faulty module in run mode
        mode = 2'b00;
        for (int i = 0; i < 6; i++) begin
            scan_in = (i == 0 || i == 3);
            #0.5;
            chk(scan_out == scan_in, "R9 run bypass", int'(scan_out), int'(scan_in));
            nxt();
            chk(chip_sel == 1'b0 && pix_sel == '0, "R9 never selected", int'({chip_sel, pix_sel}), 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule